// File: doc/BRIEF.md
# Power-On Sequencing and Reset Controller

This block decides when a multi-regulator supply is powered and in what order its outputs come up. It wakes on a rising edge of either of two wake inputs, a key or an accessory line, which are treated the same. It then enables the four default regulators one after another: core, pad, analog, then oscillator. A fixed number of timer ticks separates each enable from the next. The enable bits from the register file are then passed through to the regulators, gated by the sequencing stage and by the fault state.

An active-low reset goes to the host. It is released a long, programmable time after the pad regulator reports that its output is good. The first power-up uses one delay. Every later reset event uses a second, longer delay, counted from the moment the cause clears. The host keeps the supply on by raising power-good, and it may take as long as it likes to do so. If the wake input is released before power-good arrives, the controller drops back to standby. Once power-good is latched, the wake inputs are ignored. A falling power-good shuts everything down and asserts the register-file clear.

An undervoltage or overtemperature flag blanks every regulator enable and pulls reset low. When the flag clears, the enables return to the states the register file still holds. All delays come from one reference clock through a tick divider. All comparator inputs are taken as asynchronous digital flags and pass through a two-flop synchroniser.

Top module: `supply_sequencer`

## Requirements
- R1: While `rstN` is low, and in standby afterwards, every bit of `ldoEn` is 0, `resetN` is 0 and `regClear` is 1.
- R2: A rising edge on `wakeKey` or on `wakeAux` (both act identically) seen in standby starts power-up. Index 0 (core) of `ldoEn` rises 3 clock cycles after the input edge, and `regClear` falls with it.
- R3: The default regulators come up in the order index 0 (core), 1 (pad), 2 (analog), 3 (oscillator). Consecutive enables are `STAGGER_TICKS`×`TICK_DIV` cycles apart, except that the first gap may be up to one tick shorter. Indices at `DEF_COUNT` and above are permitted from the same cycle as index 3.
- R4: Each bit of `ldoEn` is the matching bit of `regEn`, gated by the sequencing permission and by the absence of a fault. A `regEn` bit of 0 keeps its output off.
- R5: On the first power-up, `resetN` rises `FIRST_RST_TICKS` ticks (±1 tick plus the 2-cycle synchroniser) after `padGood` rises, provided pad enable (index 1) is on.
- R6: After reset has once been released, a fault, loss of `padGood` or clearing pad enable drives `resetN` low. `resetN` then rises `LATER_RST_TICKS` ticks after the cause clears.
- R7: If both wake inputs are low before `hostPgood` has been seen high, the controller returns to standby 3 cycles after the release.
- R8: Once `hostPgood` has been latched, wake-input edges and levels have no effect on `ldoEn`, `resetN` or `regClear`.
- R9: A falling `hostPgood` after it was latched returns the controller to standby: all outputs off, `regClear` high and `resetN` low, within 4 cycles.
- R10: While `uvloFlag` or `otFlag` is high, all of `ldoEn` is 0 and `resetN` is low. `otOk` reads 0 during a thermal fault. When the flag clears, `ldoEn` returns to its previous value.
- R11: `pwrOn` is the combinational OR of `wakeKey`, `wakeAux` and `hostPgood`.
- R12: A power-up attempted while `uvloFlag` is high keeps `resetN` low and all enables off. When the flag clears, the first-power-up reset delay applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low logic reset |
| wakeKey | input | 1 | Power key wake input, active high |
| wakeAux | input | 1 | Accessory wake input, active high |
| hostPgood | input | 1 | Host power-good, holds the supply on |
| uvloFlag | input | 1 | Undervoltage comparator flag |
| otFlag | input | 1 | Overtemperature comparator flag |
| padGood | input | 1 | Pad output above its good threshold |
| regEn | input | NUM_REG | Enable bits from the register file |
| ldoEn | output | NUM_REG | Gated regulator enables |
| resetN | output | 1 | Active-low reset to the host |
| pwrOn | output | 1 | OR of the wake inputs and power-good |
| regClear | output | 1 | Register-file clear, high in standby |
| otOk | output | 1 | Thermal status, 0 during a thermal fault |

## Verification
Every asynchronous input passes through two flops. A wake edge or a host release therefore changes the state register on the third clock, and `ldoEn` follows that register combinationally. A fault flag blanks `ldoEn` after two clocks, and `resetN` follows one clock later. The bench drives inputs on the falling edge and counts falling edges until each output moves. It checks a fixed latency for synchroniser paths and a one-tick window for every tick-timed delay (enable spacing and the two reset delays), because the tick divider runs freely. A `regEn` change acts in the same cycle, so the bench samples it on the next falling edge.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_SEQ = 2'd1,
    ST_RUN = 2'd2
  } seq_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic active;    // any state but standby
    logic startSeq;  // wake edge accepted this cycle
    logic stageInc;  // advance to next default regulator
  } ctrl_strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic wakeEdge;
    logic wakeHeld;
    logic pgood;
    logic stageDone;
    logic lastStage;
  } dp_status_t;

endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= '0;
      dout <= '0;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import supply_seq_pkg::*;
#(
  parameter int NUM_REG         = 8,
  parameter int DEF_COUNT       = 4,
  parameter int PAD_IDX         = 1,
  parameter int TICK_DIV        = 48,
  parameter int STAGGER_TICKS   = 100,
  parameter int FIRST_RST_TICKS = 100000,
  parameter int LATER_RST_TICKS = 250000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wakeKey,
  input  logic               wakeAux,
  input  logic               hostPgood,
  input  logic               uvloFlag,
  input  logic               otFlag,
  input  logic               padGood,
  input  logic [NUM_REG-1:0] regEn,
  input  ctrl_strobe_t       strobe,
  output dp_status_t         status,
  output logic [NUM_REG-1:0] ldoEn,
  output logic               resetN,
  output logic               otOk
);
  localparam int DIV_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int STG_W   = $clog2(STAGGER_TICKS + 1);
  localparam int STAGE_W = $clog2(DEF_COUNT + 1);
  localparam int RST_MAX = (LATER_RST_TICKS > FIRST_RST_TICKS) ? LATER_RST_TICKS : FIRST_RST_TICKS;
  localparam int RST_W   = $clog2(RST_MAX + 1);
  localparam logic [DIV_W-1:0]   DIV_LAST   = DIV_W'(TICK_DIV - 1);
  localparam logic [STG_W-1:0]   STG_LAST   = STG_W'(STAGGER_TICKS - 1);
  localparam logic [STAGE_W-1:0] STAGE_END  = STAGE_W'(DEF_COUNT);
  localparam logic [RST_W-1:0]   FIRST_LAST = RST_W'(FIRST_RST_TICKS - 1);
  localparam logic [RST_W-1:0]   LATER_LAST = RST_W'(LATER_RST_TICKS - 1);

  // input synchronisers
  logic [5:0] syncIn, syncOut;
  logic keyS, auxS, pgoodS, uvloS, otS, padS;
  assign syncIn = {wakeKey, wakeAux, hostPgood, uvloFlag, otFlag, padGood};

  seq_sync #(.WIDTH(6)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (syncIn),
    .dout (syncOut)
  );

  assign {keyS, auxS, pgoodS, uvloS, otS, padS} = syncOut;

  // wake edge detection
  logic keyDly, auxDly;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyDly <= 1'b0;
      auxDly <= 1'b0;
    end else begin
      keyDly <= keyS;
      auxDly <= auxS;
    end
  end

  // free-running tick divider
  logic [DIV_W-1:0] divCnt;
  logic tick;
  assign tick = (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // stagger spacing counter
  logic [STG_W-1:0] stagCnt;
  logic stagDone;
  assign stagDone = tick && (stagCnt == STG_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                                 stagCnt <= '0;
    else if (!strobe.active || strobe.startSeq || strobe.stageInc) stagCnt <= '0;
    else if (stagDone)                                         stagCnt <= '0;
    else if (tick)                                             stagCnt <= stagCnt + 1'b1;
  end

  // sequencing stage: number of default regulators permitted
  logic [STAGE_W-1:0] stage;
  logic lastStage;
  assign lastStage = (stage == STAGE_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 stage <= '0;
    else if (strobe.startSeq)  stage <= STAGE_W'(1);
    else if (!strobe.active)   stage <= '0;
    else if (strobe.stageInc)  stage <= stage + 1'b1;
  end

  // enable gating
  logic faultS;
  logic [NUM_REG-1:0] allow;
  assign faultS = uvloS | otS;

  for (genvar i = 0; i < NUM_REG; i++) begin : g_allow
    if (i < DEF_COUNT) begin : g_def
      assign allow[i] = (stage > STAGE_W'(i));
    end else begin : g_rest
      assign allow[i] = lastStage;
    end
  end

  assign ldoEn = regEn & allow & {NUM_REG{strobe.active & ~faultS}};

  // reset timer
  logic [RST_W-1:0] rstCnt;
  logic firstDone, resetReg, rstHold;
  logic [RST_W-1:0] rstLimit;
  assign rstHold  = ~strobe.active | faultS | ~padS | ~ldoEn[PAD_IDX];
  assign rstLimit = firstDone ? LATER_LAST : FIRST_LAST;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCnt    <= '0;
      resetReg  <= 1'b0;
      firstDone <= 1'b0;
    end else begin
      if (!strobe.active) firstDone <= 1'b0;
      if (rstHold) begin
        rstCnt   <= '0;
        resetReg <= 1'b0;
      end else if (!resetReg && tick) begin
        if (rstCnt == rstLimit) begin
          resetReg  <= 1'b1;
          firstDone <= 1'b1;
        end else begin
          rstCnt <= rstCnt + 1'b1;
        end
      end
    end
  end

  assign resetN = resetReg;
  assign otOk   = ~otS;

  assign status.wakeEdge  = (keyS & ~keyDly) | (auxS & ~auxDly);
  assign status.wakeHeld  = keyS | auxS;
  assign status.pgood     = pgoodS;
  assign status.stageDone = stagDone;
  assign status.lastStage = lastStage;

endmodule

// File: rtl/seq_control.sv
module seq_control
  import supply_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  dp_status_t   status,
  output ctrl_strobe_t strobe,
  output logic         regClear
);
  seq_state_e state;
  logic hostLatched;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_OFF;
      hostLatched <= 1'b0;
    end else begin
      case (state)
        ST_OFF: begin
          hostLatched <= 1'b0;
          if (status.wakeEdge) state <= ST_SEQ;
        end
        default: begin
          if (hostLatched) begin
            if (!status.pgood) begin
              state       <= ST_OFF;
              hostLatched <= 1'b0;
            end else if (state == ST_SEQ && status.lastStage) begin
              state <= ST_RUN;
            end
          end else if (status.pgood) begin
            hostLatched <= 1'b1;
            if (state == ST_SEQ && status.lastStage) state <= ST_RUN;
          end else if (!status.wakeHeld) begin
            state <= ST_OFF;
          end else if (state == ST_SEQ && status.lastStage) begin
            state <= ST_RUN;
          end
        end
      endcase
    end
  end

  assign strobe.active   = (state != ST_OFF);
  assign strobe.startSeq = (state == ST_OFF) && status.wakeEdge;
  assign strobe.stageInc = (state == ST_SEQ) && status.stageDone && !status.lastStage;
  assign regClear        = (state == ST_OFF);

endmodule

// File: rtl/supply_sequencer.sv
module supply_sequencer
  import supply_seq_pkg::*;
#(
  parameter int NUM_REG         = 8,
  parameter int DEF_COUNT       = 4,
  parameter int PAD_IDX         = 1,
  parameter int TICK_DIV        = 48,
  parameter int STAGGER_TICKS   = 100,
  parameter int FIRST_RST_TICKS = 100000,
  parameter int LATER_RST_TICKS = 250000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wakeKey,
  input  logic               wakeAux,
  input  logic               hostPgood,
  input  logic               uvloFlag,
  input  logic               otFlag,
  input  logic               padGood,
  input  logic [NUM_REG-1:0] regEn,
  output logic [NUM_REG-1:0] ldoEn,
  output logic               resetN,
  output logic               pwrOn,
  output logic               regClear,
  output logic               otOk
);
  ctrl_strobe_t strobe;
  dp_status_t   status;

  seq_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .status   (status),
    .strobe   (strobe),
    .regClear (regClear)
  );

  seq_datapath #(
    .NUM_REG         (NUM_REG),
    .DEF_COUNT       (DEF_COUNT),
    .PAD_IDX         (PAD_IDX),
    .TICK_DIV        (TICK_DIV),
    .STAGGER_TICKS   (STAGGER_TICKS),
    .FIRST_RST_TICKS (FIRST_RST_TICKS),
    .LATER_RST_TICKS (LATER_RST_TICKS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wakeKey   (wakeKey),
    .wakeAux   (wakeAux),
    .hostPgood (hostPgood),
    .uvloFlag  (uvloFlag),
    .otFlag    (otFlag),
    .padGood   (padGood),
    .regEn     (regEn),
    .strobe    (strobe),
    .status    (status),
    .ldoEn     (ldoEn),
    .resetN    (resetN),
    .otOk      (otOk)
  );

  // R11: plain OR, kept outside the clocked logic
  assign pwrOn = wakeKey | wakeAux | hostPgood;

endmodule

// File: rtl/supply_sequencer_chk.sv
module supply_sequencer_chk #(
  parameter int NUM_REG = 8,
  parameter int PAD_IDX = 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               uvloFlag,
  input logic               otFlag,
  input logic [NUM_REG-1:0] ldoEn,
  input logic               resetN,
  input logic               regClear,
  input logic               otOk
);
  logic [1:0] sinceReset;
  logic       settled;
  assign settled = (sinceReset == 2'd3);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         sinceReset <= '0;
    else if (!settled) sinceReset <= sinceReset + 1'b1;
  end

  assert_standby_outputs_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    regClear |-> (ldoEn == '0));

  assert_standby_reset_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    regClear |=> !resetN);

  assert_fault_blanks_enables_R10: assert property (@(posedge clk) disable iff (!rstN)
    (settled && ($past(uvloFlag, 2) || $past(otFlag, 2)) && ($past(uvloFlag) || $past(otFlag))
     && $past(uvloFlag, 2) == $past(uvloFlag) && $past(otFlag, 2) == $past(otFlag))
    |-> (ldoEn == '0));

  assert_thermal_flag_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    (settled && $past(otFlag, 2) && $past(otFlag)) |-> !otOk);

  assert_reset_needs_pad_R6: assert property (@(posedge clk) disable iff (!rstN)
    resetN |-> $past(ldoEn[PAD_IDX]));

endmodule

bind supply_sequencer supply_sequencer_chk #(
  .NUM_REG (NUM_REG),
  .PAD_IDX (PAD_IDX)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .uvloFlag (uvloFlag),
  .otFlag   (otFlag),
  .ldoEn    (ldoEn),
  .resetN   (resetN),
  .regClear (regClear),
  .otOk     (otOk)
);

// File: tb/test_supply_sequencer.sv
module test_supply_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NR  = 8;
  localparam int DIV = 2;
  localparam int STG = 4;
  localparam int FST = 20;
  localparam int LTR = 50;
  localparam logic [NR-1:0] EN_MASK = 8'h3F;

  logic clk = 1'b0;
  logic rstN, wakeKey, wakeAux, hostPgood, uvloFlag, otFlag, padGood;
  logic [NR-1:0] regEn, ldoEn;
  logic resetN, pwrOn, regClear, otOk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_sequencer #(
    .NUM_REG(NR), .DEF_COUNT(4), .PAD_IDX(1), .TICK_DIV(DIV),
    .STAGGER_TICKS(STG), .FIRST_RST_TICKS(FST), .LATER_RST_TICKS(LTR)
  ) i_supply_sequencer (
    .clk(clk), .rstN(rstN), .wakeKey(wakeKey), .wakeAux(wakeAux),
    .hostPgood(hostPgood), .uvloFlag(uvloFlag), .otFlag(otFlag), .padGood(padGood),
    .regEn(regEn), .ldoEn(ldoEn), .resetN(resetN), .pwrOn(pwrOn),
    .regClear(regClear), .otOk(otOk)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic checkRange(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // falling edges until resetN is high, capped
  task automatic timeReset(output int n);
    n = 0;
    while (!resetN && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic testReset;
    rstN = 0; wakeKey = 0; wakeAux = 0; hostPgood = 0;
    uvloFlag = 0; otFlag = 0; padGood = 0; regEn = EN_MASK;
    cyc(3);
    check("R1 enables in reset", ldoEn, 0);
    check("R1 resetN in reset", resetN, 0);
    check("R1 regClear in reset", regClear, 1);
    rstN = 1;
    cyc(10);
    check("R1 enables in standby", ldoEn, 0);
    check("R1 regClear in standby", regClear, 1);
  endtask

  task automatic testPowerUp;
    int t[NR];
    int n;
    foreach (t[i]) t[i] = -1;
    wakeKey = 1;
    for (int c = 1; c <= 60; c++) begin
      @(negedge clk);
      for (int i = 0; i < NR; i++) if (ldoEn[i] && t[i] < 0) t[i] = c;
    end
    check("R11 pwrOn with key", pwrOn, 1);
    check("R2 core rises 3 cycles after key edge", t[0], 3);
    check("R2 regClear low after wake", regClear, 0);
    checkRange("R3 core->pad gap", t[1] - t[0], (STG - 1) * DIV + 1, STG * DIV);
    check("R3 pad->analog gap", t[2] - t[1], STG * DIV);
    check("R3 analog->osc gap", t[3] - t[2], STG * DIV);
    check("R3 index4 with osc", t[4], t[3]);
    check("R3 index5 with osc", t[5], t[3]);
    check("R4 index6 off by regEn", t[6], -1);
    check("R4 index7 off by regEn", t[7], -1);
    check("R5 resetN low before padGood", resetN, 0);
    padGood = 1;
    timeReset(n);
    checkRange("R5 first reset delay", n, (FST - 1) * DIV + 2, FST * DIV + 3);
    hostPgood = 1;
    cyc(4);
    wakeKey = 0;
    cyc(6);
    check("R8 held on by power-good", ldoEn, EN_MASK);
  endtask

  task automatic testWakeIgnored;
    for (int k = 0; k < 3; k++) begin
      wakeKey = 1; cyc(4); wakeKey = 0; wakeAux = 1; cyc(4); wakeAux = 0; cyc(4);
    end
    check("R8 enables after wake toggles", ldoEn, EN_MASK);
    check("R8 resetN after wake toggles", resetN, 1);
    check("R8 regClear after wake toggles", regClear, 0);
  endtask

  task automatic testFaults;
    int tEn, n;
    uvloFlag = 1;
    cyc(4);
    check("R10 enables off in undervoltage", ldoEn, 0);
    check("R6 resetN low in undervoltage", resetN, 0);
    uvloFlag = 0;
    tEn = -1; n = 0;
    while (!resetN && n < 400) begin
      @(negedge clk); n++;
      if (tEn < 0 && ldoEn == EN_MASK) tEn = n;
    end
    check("R10 enables restored after undervoltage", tEn, 2);
    checkRange("R6 later reset delay after undervoltage", n, (LTR - 1) * DIV + 2, LTR * DIV + 3);
    otFlag = 1;
    cyc(3);
    check("R10 otOk low in thermal fault", otOk, 0);
    check("R10 enables off in thermal fault", ldoEn, 0);
    otFlag = 0;
    timeReset(n);
    check("R10 otOk restored", otOk, 1);
    check("R10 enables restored after thermal", ldoEn, EN_MASK);
    checkRange("R6 later reset delay after thermal", n, (LTR - 1) * DIV + 2, LTR * DIV + 3);
  endtask

  task automatic testPadDisable;
    int n;
    regEn = EN_MASK & ~8'h02;
    cyc(1);
    check("R4 pad follows regEn", ldoEn, EN_MASK & ~8'h02);
    cyc(2);
    check("R6 resetN low on pad disable", resetN, 0);
    regEn = EN_MASK;
    timeReset(n);
    checkRange("R6 later reset delay after pad enable", n, (LTR - 1) * DIV, LTR * DIV + 3);
  endtask

  task automatic testPgoodFall;
    hostPgood = 0; padGood = 0;
    cyc(5);
    check("R9 enables off after power-good falls", ldoEn, 0);
    check("R9 regClear after power-good falls", regClear, 1);
    check("R9 resetN after power-good falls", resetN, 0);
    check("R11 pwrOn all low", pwrOn, 0);
  endtask

  task automatic testAbort;
    int t;
    wakeAux = 1;
    t = -1;
    for (int c = 1; c <= 6; c++) begin
      @(negedge clk);
      if (t < 0 && ldoEn[0]) t = c;
    end
    check("R2 aux wake starts core", t, 3);
    check("R11 pwrOn with aux", pwrOn, 1);
    cyc(5);
    wakeAux = 0;
    cyc(2);
    check("R7 still up 2 cycles after release", regClear, 0);
    cyc(1);
    check("R7 standby 3 cycles after release", regClear, 1);
    check("R7 enables off after release", ldoEn, 0);
  endtask

  task automatic testUvloStart;
    int tEn, n;
    uvloFlag = 1; padGood = 1;
    cyc(5);
    wakeKey = 1;
    cyc(200);
    check("R12 started under undervoltage", regClear, 0);
    check("R12 enables off under undervoltage", ldoEn, 0);
    check("R12 resetN low under undervoltage", resetN, 0);
    uvloFlag = 0;
    tEn = -1; n = 0;
    while (!resetN && n < 400) begin
      @(negedge clk); n++;
      if (tEn < 0 && ldoEn == EN_MASK) tEn = n;
    end
    check("R12 enables after undervoltage clears", tEn, 2);
    checkRange("R12 first delay applies", n, (FST - 1) * DIV + 2, FST * DIV + 3);
    hostPgood = 1; cyc(4); wakeKey = 0; cyc(6);
    check("R8 latched after late start", ldoEn, EN_MASK);
  endtask

  initial begin
    testReset();
    testPowerUp();
    testWakeIgnored();
    testFaults();
    testPadDisable();
    testPgoodFall();
    testAbort();
    testUvloStart();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule